// File: doc/BRIEF.md
# Line Ownership Arbiter for Deterministic Shared-Memory Execution

This block keeps a small direct-mapped table of sharing state for cache-line-sized blocks of memory. For each memory access it decides whether the requesting thread may go ahead on its own or must first hold the deterministic token. An access may bypass the token in two cases: it touches a line the thread already owns privately, or it reads a line that has been marked shared. Every other access is a slow path. A slow-path access proceeds only when the thread holds the token and every other thread is parked waiting for that token. This makes each change of sharing state happen at a point in the execution that does not vary from run to run.

Each entry is untouched, privately owned by one thread, or shared. The table records no identity of sharers and keeps no modified or invalid state. The decision is combinational on the current request. The table is written on the clock edge that ends the cycle in which the access is granted, so the new state governs the next cycle. A stalled request is simply presented again on later cycles until it is granted.

Top module: `share_own_ctrl`

## Requirements
- R1: After reset every entry is untouched, so the first access to any line raises need_token_o.
- R2: An access, read or write, by the thread that privately owns the line asserts proceed_o with need_token_o low.
- R3: A read of a shared line asserts proceed_o with need_token_o low and leaves the line shared.
- R4: The following accesses assert need_token_o: a write to a shared line, any access to a line owned by a different thread, and any access to an untouched line. Such an access asserts proceed_o only when token_held_i and others_blocked_i are both 1; otherwise it asserts wait_o.
- R5: A granted write by thread t leaves the line privately owned by t.
- R6: A granted read by thread t of an untouched line leaves the line privately owned by t.
- R7: A granted read by thread t of a line owned by another thread leaves the line shared.
- R8: While req_valid_i is 1, exactly one of proceed_o and wait_o is 1. While req_valid_i is 0, proceed_o, wait_o and need_token_o are all 0.
- R9: The decision for a request is produced in the same cycle. A state change caused by a granted access first affects the decision in the following cycle, and a stalled request changes no state.
- R10: The line entry is selected by address bits [9:5] with the defaults (32-byte lines, 32 entries), so the low 5 offset bits are ignored. Two addresses with equal bits [9:5] share one entry.
- R11: token_held_i at 1 with others_blocked_i at 0 gives no grant on the slow path: wait_o is 1 and the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request present |
| req_tid_i | input | TID_W (2) | Requesting thread id |
| req_addr_i | input | ADDR_W (32) | Byte address of the access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| token_held_i | input | 1 | Requester holds the deterministic token |
| others_blocked_i | input | 1 | All other threads are blocked waiting for the token |
| proceed_o | output | 1 | Access may be performed this cycle |
| need_token_o | output | 1 | Access is on the token path |
| wait_o | output | 1 | Access must be held and retried |

## Verification
All three outputs are due in the same cycle as the request. A table change caused by a grant is due one clock edge later. The bench therefore drives a request just after a falling edge and compares the outputs shortly after, before the next rising edge. It advances its behavioural table model only at that rising edge, and only when the model itself predicted a grant. Directed sequences walk a line through untouched, private, shared and re-owned states, including aliasing and offset cases. A long pseudo-random run then mixes threads, a few line indices and all combinations of the token inputs.

// File: rtl/share_own_pkg.sv
package share_own_pkg;
  typedef enum logic [1:0] {
    PATH_IDLE  = 2'd0,
    PATH_FAST  = 2'd1,
    PATH_GRANT = 2'd2,
    PATH_STALL = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_OWN   = 2'd1,
    UPD_SHARE = 2'd2
  } upd_e;
endpackage

// File: rtl/share_own_index.sv
module share_own_index #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  assign idx_o = addr_i[OFFSET_W +: IDX_W];
endmodule

// File: rtl/share_own_table.sv
module share_own_table
  import share_own_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int TID_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_shared_o,
  output logic [TID_W-1:0] rd_owner_o,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  upd_e             wr_kind_i,
  input  logic [TID_W-1:0] wr_owner_i
);
  logic             ent_valid  [ENTRIES];
  logic             ent_shared [ENTRIES];
  logic [TID_W-1:0] ent_owner  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    assign hit = (wr_idx_i == IDX_W'(e)) && (wr_kind_i != UPD_NONE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_valid[e]  <= 1'b0;
        ent_shared[e] <= 1'b0;
        ent_owner[e]  <= '0;
      end else if (hit) begin
        ent_valid[e]  <= 1'b1;
        ent_shared[e] <= (wr_kind_i == UPD_SHARE);
        ent_owner[e]  <= (wr_kind_i == UPD_OWN) ? wr_owner_i : '0;
      end
    end
  end

  assign rd_valid_o  = ent_valid[rd_idx_i];
  assign rd_shared_o = ent_shared[rd_idx_i];
  assign rd_owner_o  = ent_owner[rd_idx_i];
endmodule

// File: rtl/share_own_policy.sv
module share_own_policy
  import share_own_pkg::*;
#(
  parameter int TID_W = 2
) (
  input  logic             req_valid_i,
  input  logic [TID_W-1:0] req_tid_i,
  input  logic             req_write_i,
  input  logic             token_held_i,
  input  logic             others_blocked_i,
  input  logic             ent_valid_i,
  input  logic             ent_shared_i,
  input  logic [TID_W-1:0] ent_owner_i,
  output path_e            path_o,
  output upd_e             upd_o
);
  logic own_hit, shared_rd, granted;

  assign own_hit   = ent_valid_i && !ent_shared_i && (ent_owner_i == req_tid_i);
  assign shared_rd = ent_valid_i && ent_shared_i && !req_write_i;
  assign granted   = token_held_i && others_blocked_i;

  always_comb begin
    path_o = PATH_IDLE;
    upd_o  = UPD_NONE;
    if (req_valid_i) begin
      if (own_hit || shared_rd) begin
        path_o = PATH_FAST;
      end else if (granted) begin
        path_o = PATH_GRANT;
        // read of another thread's private line demotes it to shared
        if (req_write_i || !ent_valid_i) upd_o = UPD_OWN;
        else                             upd_o = UPD_SHARE;
      end else begin
        path_o = PATH_STALL;
      end
    end
  end
endmodule

// File: rtl/share_own_ctrl.sv
module share_own_ctrl
  import share_own_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int ENTRIES     = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int OFFSET_W   = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [TID_W-1:0]  req_tid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              token_held_i,
  input  logic              others_blocked_i,
  output logic              proceed_o,
  output logic              need_token_o,
  output logic              wait_o
);
  logic [IDX_W-1:0] idx;
  logic             ent_valid, ent_shared;
  logic [TID_W-1:0] ent_owner;
  path_e            path;
  upd_e             upd;

  share_own_index #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W)) i_index (
    .addr_i (req_addr_i),
    .idx_o  (idx)
  );

  share_own_table #(.ENTRIES(ENTRIES), .TID_W(TID_W)) i_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (idx),
    .rd_valid_o  (ent_valid),
    .rd_shared_o (ent_shared),
    .rd_owner_o  (ent_owner),
    .wr_idx_i    (idx),
    .wr_kind_i   (upd),
    .wr_owner_i  (req_tid_i)
  );

  share_own_policy #(.TID_W(TID_W)) i_policy (
    .req_valid_i      (req_valid_i),
    .req_tid_i        (req_tid_i),
    .req_write_i      (req_write_i),
    .token_held_i     (token_held_i),
    .others_blocked_i (others_blocked_i),
    .ent_valid_i      (ent_valid),
    .ent_shared_i     (ent_shared),
    .ent_owner_i      (ent_owner),
    .path_o           (path),
    .upd_o            (upd)
  );

  assign proceed_o    = (path == PATH_FAST) || (path == PATH_GRANT);
  assign wait_o       = (path == PATH_STALL);
  assign need_token_o = (path == PATH_GRANT) || (path == PATH_STALL);
endmodule

// File: rtl/share_own_ctrl_chk.sv
module share_own_ctrl_chk #(
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [TID_W-1:0]  req_tid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_write_i,
  input logic              token_held_i,
  input logic              others_blocked_i,
  input logic              proceed_o,
  input logic              need_token_o,
  input logic              wait_o
);
  // R8
  a_r8_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({proceed_o, wait_o}) == 1);

  // R8
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(proceed_o || wait_o || need_token_o));

  // R4
  a_r4_grant_needs_quiesce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need_token_o && proceed_o) |-> (token_held_i && others_blocked_i));

  // R11
  a_r11_partial_token_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need_token_o && !others_blocked_i) |-> wait_o);

  // R5: after a granted write, the same thread on the same address is on the fast path
  a_r5_writer_owns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proceed_o && req_valid_i && req_write_i) |=>
      ((req_valid_i && req_tid_i == $past(req_tid_i) && req_addr_i == $past(req_addr_i))
        -> !need_token_o));
endmodule

bind share_own_ctrl share_own_ctrl_chk #(.TID_W(TID_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_tid_i        (req_tid_i),
  .req_addr_i       (req_addr_i),
  .req_write_i      (req_write_i),
  .token_held_i     (token_held_i),
  .others_blocked_i (others_blocked_i),
  .proceed_o        (proceed_o),
  .need_token_o     (need_token_o),
  .wait_o           (wait_o)
);

// File: tb/test_share_own_ctrl.sv
`timescale 1ns/1ps
module test_share_own_ctrl;
  localparam int NT  = 4;
  localparam int NE  = 32;
  localparam int OFS = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_tid_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        token_held_i = 1'b0;
  logic        others_blocked_i = 1'b0;
  logic        proceed_o, need_token_o, wait_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  int m_valid [NE];
  int m_shared[NE];
  int m_owner [NE];

  always #2.5 clk_i = ~clk_i;

  share_own_ctrl i_share_own_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_tid_i(req_tid_i),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .token_held_i(token_held_i),
    .others_blocked_i(others_blocked_i), .proceed_o(proceed_o),
    .need_token_o(need_token_o), .wait_o(wait_o)
  );

  task automatic step(input bit v, input int tid, input int addr, input bit wr,
                      input bit tok, input bit blk, input string tag);
    int  ix;
    bit  e_p, e_n, e_w, fast;
    @(negedge clk_i);
    req_valid_i = v; req_tid_i = 2'(tid); req_addr_i = 32'(addr);
    req_write_i = wr; token_held_i = tok; others_blocked_i = blk;
    #1;
    ix = (addr / (1 << OFS)) % NE;
    fast = (m_valid[ix] != 0) &&
           (((m_shared[ix] == 0) && (m_owner[ix] == tid)) || ((m_shared[ix] != 0) && !wr));
    e_p = v && (fast || (tok && blk));
    e_n = v && !fast;
    e_w = v && !e_p;
    vec_cnt++;
    if ({proceed_o, need_token_o, wait_o} !== {e_p, e_n, e_w}) begin
      err_cnt++;
      $display("FAIL %s: proceed/need/wait actual %b%b%b expected %b%b%b",
               tag, proceed_o, need_token_o, wait_o, e_p, e_n, e_w);
    end
    @(posedge clk_i);
    if (e_p && !fast) begin
      if (wr || m_valid[ix] == 0) begin
        m_valid[ix] = 1; m_shared[ix] = 0; m_owner[ix] = tid;
      end else begin
        m_shared[ix] = 1;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_shared[i] = 0; m_owner[i] = 0; end
    #12 rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R8 idle after reset");
    step(1, 0, 'h40, 0, 0, 0, "R1 untouched read needs token");
    step(1, 0, 'h40, 0, 1, 0, "R11 token without quiesce");
    step(1, 0, 'h40, 0, 0, 0, "R11 no update after partial token");
    step(1, 0, 'h40, 0, 1, 1, "R6 granted first read");
    step(1, 0, 'h40, 0, 0, 0, "R9 ownership visible next cycle");
    step(1, 0, 'h40, 1, 0, 0, "R2 owner write no token");
    step(1, 1, 'h40, 0, 0, 0, "R4 other-owned read waits");
    step(1, 1, 'h40, 0, 1, 1, "R7 granted read of other-owned");
    step(1, 2, 'h40, 0, 0, 0, "R3 shared read fast");
    step(1, 1, 'h40, 0, 0, 0, "R3 shared read stays shared");
    step(1, 2, 'h40, 1, 0, 0, "R4 shared write waits");
    step(1, 2, 'h40, 1, 1, 1, "R5 granted shared write");
    step(1, 2, 'h5F, 0, 0, 0, "R10 offset bits ignored");
    step(1, 2, 'h440, 1, 0, 0, "R10 aliased address shares entry");
    step(1, 0, 'h40, 0, 0, 0, "R5 previous owner now waits");
    step(1, 3, 'h80, 1, 1, 1, "R5 granted write to untouched");
    step(1, 3, 'h80, 0, 0, 0, "R2 owner read no token");
    step(0, 3, 'h80, 1, 1, 1, "R8 idle ignores token inputs");
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], ((r[6:4] * 7) % NE) * 32 + r[11:7], r[12],
           r[13] | r[14], r[15] | r[16], "R4 R8 random mix");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule